// File: doc/BRIEF.md
# Clock Generator Strap and Output-Enable Controller

This block is the control core of a multi-output clock generator. After reset it waits for an active-low power-good strobe. While the strobe is low it captures, once only, a set of configuration straps: three frequency-select bits and a shared-pair select bit. From then on the same pin works as a live power-down request, which is active high. The latched straps select test mode and decide whether one shared differential pair carries the third CPU clock or SRC clock 7.

In normal operation the block drives a registered enable for each CPU, SRC and PCI output. It gates those enables with the active-low CPU and PCI stop inputs and with two active-low clock-request inputs. Each clock request is tied to one SRC output. A one-byte register reached through a small write port can change which SRC output each request controls. Every asynchronous control input passes through a two-flop synchronizer, so an enable only changes on a clean clock edge.

The register write port is a valid/ready stream with no back-pressure. `cfg_wr_ready` is always high, and a beat is taken in every cycle in which `cfg_wr_valid` is high.

Top module: `clkgen_ctrl`

## Requirements
- R1: While reset is held and after its release, until a strobe arrives, every enable, `straps_valid`, `pair_is_cpu`, `fs_latched` and the test flags are 0.
- R2: When the synchronized strobe is first seen low, the block latches the straps: `fs_latched` = {fs_c, fs_b, fs_a} and `pair_is_cpu` = the pair-select strap. `straps_valid` then goes to 1 and stays there until reset.
- R3: After the latch, changes on the strap inputs do not alter `fs_latched` or `pair_is_cpu`.
- R4: With `pair_is_cpu`=1 the last CPU enable (`cpu_oe[2]`) can be active and `src_oe[7]` is 0. With `pair_is_cpu`=0 it is the other way round. The two are never high together.
- R5: Test mode is set when fs_b (`fs_latched[1]`) is latched as 1. In test mode all enables are 0. `test_hiz` = 1 when fs_c (`fs_latched[2]`) is 0, and `test_refdiv` = 1 when fs_c is 1.
- R6: After the latch, the strobe pin held high is a power-down: all enables go to 0. They come back when the pin returns low.
- R7: `cpu_stop_n`=0 clears all active CPU enables and leaves the SRC and PCI enables unchanged.
- R8: `pci_stop_n`=0 clears all PCI enables and leaves the CPU and SRC enables unchanged.
- R9: An SRC output named by a request's mapping is enabled only while at least one request mapped to it is low. SRC outputs with no request mapped to them stay enabled. By default request 0 maps to SRC4 and request 1 maps to SRC5.
- R10: A write to address 8 sets the map register. Bits [2:0] give the SRC index for request 0 and bits [6:4] give it for request 1. The reset value is 8'h54. Writes to any other address are ignored.
- R11: A change on a stop, request or strobe input reaches the enables on the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low reset |
| pgood_pd | input | 1 | Power-good strobe (low) before the latch; power-down request (high) after it |
| strap_fs | input | 3 | Strap inputs {fs_c/test-select, fs_b, fs_a} |
| strap_pair_cpu | input | 1 | Strap: 1 = shared pair is the CPU clock, 0 = SRC7 |
| cpu_stop_n | input | 1 | Active-low CPU group stop |
| pci_stop_n | input | 1 | Active-low PCI group stop |
| clk_req_n | input | 2 | Active-low clock requests |
| cfg_wr_valid | input | 1 | Write beat valid |
| cfg_wr_ready | output | 1 | Write beat accepted (always 1) |
| cfg_wr_addr | input | 4 | Register address |
| cfg_wr_data | input | 8 | Register data |
| straps_valid | output | 1 | Straps have been latched |
| fs_latched | output | 3 | Latched {fs_c, fs_b, fs_a} |
| pair_is_cpu | output | 1 | Latched pair select |
| test_mode | output | 1 | Test mode active |
| test_hiz | output | 1 | Test mode, outputs high impedance |
| test_refdiv | output | 1 | Test mode, outputs carry reference/N |
| cpu_oe | output | 3 | CPU output enables (bit 2 = shared pair) |
| src_oe | output | 8 | SRC output enables (bit 7 = shared pair) |
| pci_oe | output | 6 | PCI output enables |

## Verification
The hardest behaviour to reach from the ports is the one-shot strap latch. Its effects appear only after reset, through a strobe that later takes on a different meaning. The bench therefore repeats the full power-up sequence several times, with different strap patterns. Each time it raises the pin again to check that the latch now reads as a power-down, and it changes the straps to check that nothing is captured a second time. It also measures the three-edge latency by sampling just before and just after the expected edge, and it remaps the requests to outputs other than the defaults.

// File: rtl/clkgen_ctrl_pkg.sv
package clkgen_ctrl_pkg;
  localparam int FS_W    = 3;
  localparam int FS_B    = 1;
  localparam int FS_C    = 2;
  localparam int CFG_AW  = 4;
  localparam int CFG_DW  = 8;
  localparam int MAP_FLD = 4;

  typedef struct packed {
    logic [FS_W-1:0] fs;
    logic            pair_cpu;
  } strap_t;
endpackage

// File: rtl/clkgen_ctrl_sync.sv
module clkgen_ctrl_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[b];
        s2 <= RST_VAL[b];
      end else begin
        s1 <= d[b];
        s2 <= s1;
      end
    end
    assign q[b] = s2;
  end
endmodule

// File: rtl/clkgen_ctrl_strap.sv
module clkgen_ctrl_strap
  import clkgen_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe_s,
  input  strap_t          strap_s,
  output logic            valid,
  output strap_t          strap_q,
  output logic            pd,
  output logic            test_mode,
  output logic            test_hiz,
  output logic            test_refdiv
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      strap_q <= '0;
    end else if (!valid && !strobe_s) begin
      valid   <= 1'b1;
      strap_q <= strap_s;
    end
  end

  assign pd          = valid && strobe_s;
  assign test_mode   = valid && strap_q.fs[FS_B];
  assign test_hiz    = test_mode && !strap_q.fs[FS_C];
  assign test_refdiv = test_mode && strap_q.fs[FS_C];

  a_r2_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> valid);
  a_r3_straps_hold: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> $stable(strap_q));
endmodule

// File: rtl/clkgen_ctrl_reqmap.sv
module clkgen_ctrl_reqmap
  import clkgen_ctrl_pkg::*;
#(
  parameter int N_SRC    = 8,
  parameter int N_REQ    = 2,
  parameter int MAP_ADDR = 8,
  parameter int FIRST_DEFAULT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [CFG_AW-1:0] wr_addr,
  input  logic [CFG_DW-1:0] wr_data,
  input  logic [N_REQ-1:0]  req_s,
  output logic [N_SRC-1:0]  src_ok
);
  localparam int IW = $clog2(N_SRC);

  logic [IW-1:0] map_q [N_REQ];
  logic          hit;
  assign hit = wr_valid && (wr_addr == CFG_AW'(MAP_ADDR));

  for (genvar k = 0; k < N_REQ; k++) begin : g_map
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   map_q[k] <= IW'(FIRST_DEFAULT + k);
      else if (hit) map_q[k] <= wr_data[k*MAP_FLD +: IW];
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    always_comb begin
      logic mapped, asked;
      mapped = 1'b0;
      asked  = 1'b0;
      for (int k = 0; k < N_REQ; k++) begin
        if (map_q[k] == IW'(i)) begin
          mapped = 1'b1;
          if (!req_s[k]) asked = 1'b1;
        end
      end
      src_ok[i] = !mapped || asked;
    end
  end
endmodule

// File: rtl/clkgen_ctrl_oe.sv
module clkgen_ctrl_oe #(
  parameter int N_CPU = 3,
  parameter int N_SRC = 8,
  parameter int N_PCI = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             pd,
  input  logic             test_mode,
  input  logic             pair_cpu,
  input  logic             cpu_go,
  input  logic             pci_go,
  input  logic [N_SRC-1:0] src_ok,
  output logic [N_CPU-1:0] cpu_oe,
  output logic [N_SRC-1:0] src_oe,
  output logic [N_PCI-1:0] pci_oe
);
  logic run;
  logic [N_CPU-1:0] cpu_d;
  logic [N_SRC-1:0] src_d;

  assign run = valid && !pd && !test_mode;

  for (genvar j = 0; j < N_CPU; j++) begin : g_cpu
    if (j == N_CPU - 1) begin : g_shared
      assign cpu_d[j] = run && cpu_go && pair_cpu;
    end else begin : g_fixed
      assign cpu_d[j] = run && cpu_go;
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (i == N_SRC - 1) begin : g_shared
      assign src_d[i] = run && src_ok[i] && !pair_cpu;
    end else begin : g_fixed
      assign src_d[i] = run && src_ok[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_oe <= '0;
      src_oe <= '0;
      pci_oe <= '0;
    end else begin
      cpu_oe <= cpu_d;
      src_oe <= src_d;
      pci_oe <= {N_PCI{run && pci_go}};
    end
  end

  a_r4_pair_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_oe[N_CPU-1] && src_oe[N_SRC-1]));
  a_r5_test_blank: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |=> (cpu_oe == '0 && src_oe == '0 && pci_oe == '0));
  a_r6_pd_blank: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> (cpu_oe == '0 && src_oe == '0 && pci_oe == '0));
  a_r7_cpu_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_go |=> cpu_oe == '0);
  a_r8_pci_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !pci_go |=> pci_oe == '0);
endmodule

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl
  import clkgen_ctrl_pkg::*;
#(
  parameter int N_CPU    = 3,
  parameter int N_SRC    = 8,
  parameter int N_PCI    = 6,
  parameter int N_REQ    = 2,
  parameter int MAP_ADDR = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pgood_pd,
  input  logic [FS_W-1:0]   strap_fs,
  input  logic              strap_pair_cpu,
  input  logic              cpu_stop_n,
  input  logic              pci_stop_n,
  input  logic [N_REQ-1:0]  clk_req_n,
  input  logic              cfg_wr_valid,
  output logic              cfg_wr_ready,
  input  logic [CFG_AW-1:0] cfg_wr_addr,
  input  logic [CFG_DW-1:0] cfg_wr_data,
  output logic              straps_valid,
  output logic [FS_W-1:0]   fs_latched,
  output logic              pair_is_cpu,
  output logic              test_mode,
  output logic              test_hiz,
  output logic              test_refdiv,
  output logic [N_CPU-1:0]  cpu_oe,
  output logic [N_SRC-1:0]  src_oe,
  output logic [N_PCI-1:0]  pci_oe
);
  localparam int SW = 1 + FS_W + 1 + 2 + N_REQ;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, {(FS_W + 1){1'b0}}, 2'b11, {N_REQ{1'b1}}};

  logic [SW-1:0]    raw, synced;
  logic             strobe_s, cstop_s, pstop_s, pd;
  logic [N_REQ-1:0] req_s;
  strap_t           strap_s, strap_q;
  logic [N_SRC-1:0] src_ok;

  assign raw = {pgood_pd, strap_fs, strap_pair_cpu, cpu_stop_n, pci_stop_n, clk_req_n};
  assign {strobe_s, strap_s, cstop_s, pstop_s, req_s} = synced;
  assign cfg_wr_ready = 1'b1;

  clkgen_ctrl_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced));

  clkgen_ctrl_strap u_strap (
    .clk(clk), .rst_n(rst_n), .strobe_s(strobe_s), .strap_s(strap_s),
    .valid(straps_valid), .strap_q(strap_q), .pd(pd), .test_mode(test_mode),
    .test_hiz(test_hiz), .test_refdiv(test_refdiv));

  assign fs_latched  = strap_q.fs;
  assign pair_is_cpu = strap_q.pair_cpu;

  clkgen_ctrl_reqmap #(.N_SRC(N_SRC), .N_REQ(N_REQ), .MAP_ADDR(MAP_ADDR)) u_map (
    .clk(clk), .rst_n(rst_n), .wr_valid(cfg_wr_valid && cfg_wr_ready),
    .wr_addr(cfg_wr_addr), .wr_data(cfg_wr_data), .req_s(req_s), .src_ok(src_ok));

  clkgen_ctrl_oe #(.N_CPU(N_CPU), .N_SRC(N_SRC), .N_PCI(N_PCI)) u_oe (
    .clk(clk), .rst_n(rst_n), .valid(straps_valid), .pd(pd), .test_mode(test_mode),
    .pair_cpu(strap_q.pair_cpu), .cpu_go(cstop_s), .pci_go(pstop_s), .src_ok(src_ok),
    .cpu_oe(cpu_oe), .src_oe(src_oe), .pci_oe(pci_oe));

  a_r1_idle_before_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !straps_valid |=> (cpu_oe == '0 && src_oe == '0 && pci_oe == '0));
endmodule

// File: tb/clkgen_ctrl_tb.sv
module clkgen_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pgood_pd = 1'b1;
  logic [2:0] strap_fs = '0;
  logic strap_pair_cpu = 1'b0;
  logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1;
  logic [1:0] clk_req_n = 2'b11;
  logic cfg_wr_valid = 1'b0;
  logic cfg_wr_ready;
  logic [3:0] cfg_wr_addr = '0;
  logic [7:0] cfg_wr_data = '0;
  logic straps_valid, pair_is_cpu, test_mode, test_hiz, test_refdiv;
  logic [2:0] fs_latched, cpu_oe;
  logic [7:0] src_oe;
  logic [5:0] pci_oe;

  always #10 clk = ~clk;

  clkgen_ctrl u_dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state
  bit m_valid; logic [2:0] m_fs; bit m_cpu2; int m_map_a, m_map_b;

  logic [24:0] exp_q[$];
  string tag_q[$];
  event ev;

  function automatic logic [24:0] model();
    logic run; logic [2:0] c; logic [7:0] s; logic [5:0] p; logic tm;
    tm  = m_valid && m_fs[1];
    run = m_valid && !tm && !pgood_pd;
    for (int j = 0; j < 3; j++) c[j] = run && cpu_stop_n && (j < 2 || m_cpu2);
    for (int i = 0; i < 8; i++) begin
      bit mapped = 0, asked = 0;
      if (m_map_a == i) begin mapped = 1; if (!clk_req_n[0]) asked = 1; end
      if (m_map_b == i) begin mapped = 1; if (!clk_req_n[1]) asked = 1; end
      s[i] = run && (!mapped || asked) && (i < 7 || !m_cpu2);
    end
    p = {6{run && pci_stop_n}};
    return {m_valid, m_valid ? m_fs : 3'b000, m_valid && m_cpu2, tm,
            tm && !m_fs[2], tm && m_fs[2], c, s, p};
  endfunction

  function automatic logic [24:0] actual();
    return {straps_valid, fs_latched, pair_is_cpu, test_mode, test_hiz,
            test_refdiv, cpu_oe, src_oe, pci_oe};
  endfunction

  // monitor: pops expectations and compares with the design outputs
  initial forever begin
    @(ev);
    while (exp_q.size() > 0) begin
      logic [24:0] e, a; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front(); a = actual();
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", t, a, e);
      end
    end
  end

  task automatic expect_now(string tag);
    exp_q.push_back(model()); tag_q.push_back(tag); -> ev;
    #1;
  endtask

  task automatic settle_check(string tag);
    repeat (5) @(negedge clk);
    expect_now(tag);
  endtask

  task automatic direct(string tag, logic [24:0] a, logic [24:0] e);
    checks++;
    if (a !== e) begin errors++; $display("FAIL %s actual=%h expected=%h", tag, a, e); end
  endtask

  task automatic power_up(logic [2:0] fs, bit cpu2);
    @(negedge clk);
    rst_n = 0; pgood_pd = 1; strap_fs = fs; strap_pair_cpu = cpu2;
    cpu_stop_n = 1; pci_stop_n = 1; clk_req_n = 2'b11;
    m_valid = 0; m_fs = fs; m_cpu2 = cpu2; m_map_a = 4; m_map_b = 5;
    repeat (3) @(negedge clk);
    expect_now("R1 in reset");
    rst_n = 1;
    settle_check("R1 after reset, no strobe");
    pgood_pd = 0; m_valid = 1;
    settle_check("R2 straps latched");
  endtask

  task automatic cfg_write(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_wr_valid = 1; cfg_wr_addr = a; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_valid = 0;
    if (a == 4'd8) begin m_map_a = d[2:0]; m_map_b = d[6:4]; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    power_up(3'b001, 1'b1);
    direct("R10 ready high", {24'd0, cfg_wr_ready}, 25'd1);
    strap_fs = 3'b110; strap_pair_cpu = 0;
    settle_check("R3 strap change ignored");
    clk_req_n[0] = 0;
    settle_check("R9 request 0 enables SRC4");
    // R11 latency: change lands on third edge
    @(negedge clk); clk_req_n[1] = 0;
    repeat (2) @(negedge clk);
    direct("R11 not before third edge", {24'd0, src_oe[5]}, 25'd0);
    @(negedge clk);
    direct("R11 on third edge", {24'd0, src_oe[5]}, 25'd1);
    clk_req_n = 2'b11;
    settle_check("R9 requests released");
    cpu_stop_n = 0;
    settle_check("R7 cpu stop");
    cpu_stop_n = 1; pci_stop_n = 0;
    settle_check("R8 pci stop");
    pci_stop_n = 1;
    cfg_write(4'd3, 8'h20);
    settle_check("R10 write to other address ignored");
    cfg_write(4'd8, 8'h20);
    settle_check("R10 remap to SRC0 and SRC2");
    clk_req_n = 2'b01;
    settle_check("R10 request 1 drives SRC2");
    pgood_pd = 1;
    settle_check("R6 power-down blanks");
    strap_fs = 3'b000;
    pgood_pd = 0;
    settle_check("R6 power-down released, R3 no relatch");
    power_up(3'b101, 1'b0);
    settle_check("R4 pair as SRC7, R10 default map");
    clk_req_n = 2'b10;
    settle_check("R9 default SRC4 after reset");
    power_up(3'b010, 1'b1);
    settle_check("R5 test mode hi-z");
    power_up(3'b110, 1'b0);
    settle_check("R5 test mode ref/N");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule